// File: doc/BRIEF.md
# Fixed Off-Time Bridge Current Chopper

This block regulates the current of one motor bridge by chopping. While the bridge conducts, the current rises. An already synchronized comparator input reports when the sensed current has passed the reference. That trip starts a one-shot off interval of programmable length. When the interval expires, a programmable deadtime follows, and then the bridge is switched back on. The real off time therefore equals the one-shot length plus the deadtime. The block issues no free-running carrier: every off interval is started by a trip.

Two guards shape the on phase. A blanking window at the start of every on phase masks the comparator, so the current spike that follows turn-on cannot start a new off interval. A minimum on time keeps the bridge on for a guaranteed number of cycles even when a valid trip arrives earlier. A low enable removes both outputs in the same cycle. When enable returns, the block restarts in the on phase with blanking active.

The outputs are a bridge-on request and an off-phase flag for a downstream gate sequencer. All durations are counted in system clock cycles and are supplied as plain inputs.

Top module: `fixed_off_chopper`

## Requirements
- R1: When a trip is accepted in the on phase and the minimum on time is already met, `off_phase` is 1 and `bridge_on` is 0 from the next clock edge.
- R2: The off phase (`off_phase`=1) lasts exactly `toff_cyc` cycles, or 1 cycle when `toff_cyc` is 0. Trips that arrive in it do not extend it.
- R3: After the off phase, `bridge_on` and `off_phase` are both 0 for exactly `tdead_cyc` cycles, and then `bridge_on` returns to 1. A deadtime of 0 goes straight from the off phase to the on phase.
- R4: During the first `tblank_cyc` cycles of every on phase, the trip input is ignored. With the trip held at 1, an on phase lasts at least `tblank_cyc`+1 cycles.
- R5: Every on phase that ends by a trip lasts at least `tmin_cyc` cycles. A trip that is accepted earlier than that is held, and it ends the on phase when the minimum is reached. With the trip held at 1, the on phase lasts max(`tblank_cyc`+1, `tmin_cyc`, 1) cycles.
- R6: While `en` is 0, `bridge_on` and `off_phase` are both 0 in that same cycle, whatever phase the block was in.
- R7: A trip that arrives during blanking, the off phase or the deadtime is discarded and is not acted on later.
- R8: At the first clock edge that sees `en` at 1 after a low period, the block enters the on phase (`bridge_on`=1) with blanking restarted.
- R9: An active-low `rst_n` clears the block to the idle state, with both outputs 0, immediately. After release, the first edge with `en` at 1 enters the on phase.
- R10: `bridge_on` and `off_phase` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; 0 forces the bridge off at once |
| trip | input | 1 | Synchronized comparator: 1 when the sensed current exceeds the reference |
| toff_cyc | input | CW | One-shot off time in cycles (0 treated as 1) |
| tblank_cyc | input | CW | Blanking window after turn-on, in cycles |
| tmin_cyc | input | CW | Minimum on time in cycles |
| tdead_cyc | input | CW | Deadtime before turn-on, in cycles |
| bridge_on | output | 1 | Request to drive the bridge on |
| off_phase | output | 1 | One-shot off interval in progress |

## Verification
A trip that the design accepts shows up on `off_phase` one clock edge after the edge that samples it. An enable rise shows up on `bridge_on` one edge later. An enable fall or a reset clears both outputs in the same cycle, with no edge needed. The bench therefore changes its inputs on the falling clock edge. It samples registered results at the next falling edge, and it samples the combinational enable and reset effects 1 ns after the change. Phase lengths are measured by counting consecutive falling-edge samples of each output. These counts are compared with the max(...) formulas stated in the requirements.

// File: rtl/fixed_off_chopper.sv
module fixed_off_chopper #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          trip,
  input  logic [CW-1:0] toff_cyc,
  input  logic [CW-1:0] tblank_cyc,
  input  logic [CW-1:0] tmin_cyc,
  input  logic [CW-1:0] tdead_cyc,
  output logic          bridge_on,
  output logic          off_phase
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  localparam logic [CW-1:0] ONE     = {{(CW-1){1'b0}}, 1'b1};

  typedef enum logic [1:0] {S_IDLE, S_ON, S_OFF, S_DEAD} phase_t;

  phase_t        ph;
  logic [CW-1:0] cnt;
  logic          held;

  wire [CW-1:0] cnt_nx    = (cnt == CNT_MAX) ? cnt : cnt + ONE;
  wire [CW-1:0] off_len   = (toff_cyc == '0) ? ONE : toff_cyc;
  wire          masked    = cnt < tblank_cyc;
  wire          hit       = trip & ~masked;
  wire          min_ok    = cnt_nx >= tmin_cyc;
  wire          end_on    = (hit | held) & min_ok;
  wire          end_off   = cnt_nx >= off_len;
  wire          end_dead  = cnt_nx >= tdead_cyc;
  wire          no_dead   = tdead_cyc == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= S_IDLE;
      cnt  <= '0;
      held <= 1'b0;
    end else if (!en) begin
      ph   <= S_IDLE;
      cnt  <= '0;
      held <= 1'b0;
    end else begin
      case (ph)
        S_IDLE: begin
          ph   <= S_ON;
          cnt  <= '0;
          held <= 1'b0;
        end
        S_ON: begin
          if (end_on) begin
            ph   <= S_OFF;
            cnt  <= '0;
            held <= 1'b0;
          end else begin
            cnt  <= cnt_nx;
            held <= held | hit;
          end
        end
        S_OFF: begin
          if (end_off) begin
            ph  <= no_dead ? S_ON : S_DEAD;
            cnt <= '0;
          end else begin
            cnt <= cnt_nx;
          end
        end
        default: begin
          if (end_dead) begin
            ph  <= S_ON;
            cnt <= '0;
          end else begin
            cnt <= cnt_nx;
          end
        end
      endcase
    end
  end

  assign bridge_on = en & (ph == S_ON);
  assign off_phase = en & (ph == S_OFF);

endmodule

// File: rtl/chopper_props.sv
module chopper_props #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [CW-1:0] toff_cyc,
  input logic [CW-1:0] tblank_cyc,
  input logic [CW-1:0] tmin_cyc,
  input logic          bridge_on,
  input logic          off_phase
);

  localparam logic [CW:0] RUN_MAX = {(CW+1){1'b1}};

  logic [CW:0] on_run;
  logic [CW:0] off_run;
  wire  [CW:0] off_want = (toff_cyc == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, toff_cyc};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_run  <= '0;
      off_run <= '0;
    end else begin
      on_run  <= bridge_on ? ((on_run == RUN_MAX) ? on_run : on_run + 1'b1) : '0;
      off_run <= off_phase ? ((off_run == RUN_MAX) ? off_run : off_run + 1'b1) : '0;
    end
  end

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bridge_on && off_phase));

  assert_enable_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!bridge_on && !off_phase));

  assert_enable_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |=> (bridge_on || !en));

  assert_off_from_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(off_phase) |-> $past(bridge_on));

  assert_off_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(off_phase) && en) |-> (off_run == off_want));

  assert_min_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bridge_on) && off_phase) |-> (on_run >= {1'b0, tmin_cyc}));

  assert_blanking_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bridge_on) && off_phase) |-> (on_run > {1'b0, tblank_cyc}));

endmodule

bind fixed_off_chopper chopper_props #(.CW(CW)) u_props (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .toff_cyc  (toff_cyc),
  .tblank_cyc(tblank_cyc),
  .tmin_cyc  (tmin_cyc),
  .bridge_on (bridge_on),
  .off_phase (off_phase)
);

// File: tb/sim_fixed_off_chopper.sv
`timescale 1ns/1ps
module sim_fixed_off_chopper;
  localparam int CW = 12;
  localparam int NV = 6;
  // blank, min_on, off, dead, expected on length, off length, dead length
  localparam int VEC [NV][7] = '{
    '{2, 3, 5, 2, 3, 5, 2},
    '{0, 1, 1, 0, 1, 1, 0},
    '{4, 2, 3, 1, 5, 3, 1},
    '{1, 6, 2, 3, 6, 2, 3},
    '{0, 0, 0, 0, 1, 1, 0},
    '{3, 3, 7, 4, 4, 7, 4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic trip = 1'b0;
  logic [CW-1:0] toff_cyc = '0, tblank_cyc = '0, tmin_cyc = '0, tdead_cyc = '0;
  logic bridge_on, off_phase;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  fixed_off_chopper #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .trip(trip),
    .toff_cyc(toff_cyc), .tblank_cyc(tblank_cyc), .tmin_cyc(tmin_cyc), .tdead_cyc(tdead_cyc),
    .bridge_on(bridge_on), .off_phase(off_phase)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input int b, input int m, input int o, input int d);
    en = 1'b0;
    trip = 1'b0;
    repeat (2) @(negedge clk);
    tblank_cyc = CW'(b);
    tmin_cyc = CW'(m);
    toff_cyc = CW'(o);
    tdead_cyc = CW'(d);
  endtask

  // en has just been raised at a falling edge; trip is held by the caller
  task automatic measure(input int eon, input int eoff, input int edead);
    int n;
    n = 0;
    @(negedge clk);
    while (bridge_on && n < 200) begin n++; @(negedge clk); end
    chk("R5 on length", n, eon);
    chk("R10 exclusive", int'(bridge_on & off_phase), 0);
    n = 0;
    while (off_phase && n < 200) begin n++; @(negedge clk); end
    chk("R2 off length", n, eoff);
    n = 0;
    while (!bridge_on && !off_phase && n < 200) begin n++; @(negedge clk); end
    chk("R3 dead length", n, edead);
    chk("R3 back on", int'(bridge_on), 1);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R9: reset state, even with enable high
    en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 reset bridge_on", int'(bridge_on), 0);
    chk("R9 reset off_phase", int'(off_phase), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 on after release", int'(bridge_on), 1);

    // table: trip held high, whole chop cycle measured
    for (int v = 0; v < NV; v++) begin
      setup(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      trip = 1'b1;
      en = 1'b1;
      measure(VEC[v][4], VEC[v][5], VEC[v][6]);
    end

    // R4 and R7: trips inside the blanking window are dropped
    setup(4, 1, 3, 0);
    en = 1'b1;
    @(negedge clk);
    trip = 1'b1;
    repeat (4) @(negedge clk);
    trip = 1'b0;
    repeat (8) @(negedge clk);
    chk("R4 blanked trip ignored", int'(bridge_on), 1);
    chk("R7 blanked trip not queued", int'(off_phase), 0);
    trip = 1'b1;
    @(negedge clk);
    trip = 1'b0;
    chk("R1 off after trip", int'(off_phase), 1);
    chk("R1 bridge off after trip", int'(bridge_on), 0);

    // R5: early trip held until the minimum on time
    setup(0, 6, 2, 0);
    en = 1'b1;
    @(negedge clk);
    trip = 1'b1;
    @(negedge clk);
    trip = 1'b0;
    chk("R5 stretched on", int'(bridge_on), 1);
    repeat (4) @(negedge clk);
    chk("R5 still on at cycle 6", int'(bridge_on), 1);
    @(negedge clk);
    chk("R5 off after min on", int'(off_phase), 1);

    // R7: trip during the off phase discarded
    setup(0, 1, 4, 0);
    en = 1'b1;
    @(negedge clk);
    trip = 1'b1;
    @(negedge clk);
    chk("R1 immediate off", int'(off_phase), 1);
    repeat (3) @(negedge clk);
    chk("R2 still off", int'(off_phase), 1);
    trip = 1'b0;
    @(negedge clk);
    chk("R2 on after off time", int'(bridge_on), 1);
    repeat (10) @(negedge clk);
    chk("R7 off-phase trip not queued", int'(bridge_on), 1);

    // R6: enable low clears outputs at once, in the on and off phases
    en = 1'b0;
    #1;
    chk("R6 on phase cleared", int'(bridge_on), 0);
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    trip = 1'b1;
    @(negedge clk);
    chk("R1 off before disable", int'(off_phase), 1);
    en = 1'b0;
    #1;
    chk("R6 off phase cleared", int'(off_phase), 0);
    chk("R6 bridge stays off", int'(bridge_on), 0);

    // R8: restart straight into the on phase with blanking
    @(negedge clk);
    tblank_cyc = CW'(3);
    tmin_cyc = CW'(1);
    toff_cyc = CW'(2);
    tdead_cyc = CW'(0);
    en = 1'b1;
    measure(4, 2, 0);
    chk("R8 restart done", 1, 1);

    // R9: asynchronous reset in the on phase
    trip = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 async reset clears", int'(bridge_on), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 on after second release", int'(bridge_on), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule